// File: doc/BRIEF.md
# Addressed Serial Command Receiver

This block listens on one asynchronous serial line for 11-bit frames. Each frame carries a start bit, eight data bits sent least significant bit first, an even parity bit and a stop bit. The bit timing is derived from the system clock by a fixed divider, `CLK_DIV`, which defaults to 64. The receiver waits for a falling edge on the idle-high line. It confirms the start bit at its midpoint. After that it samples each following bit once, in the middle of its bit period.

The top data bit of each frame tells the two kinds of frame apart. A frame with that bit set is an address frame. Its seven low bits are compared with the station address input. On a match the block raises a one-cycle valid-address pulse and sets a valid-address flag, which a companion transmitter can read. A frame with the top bit clear is a command frame. Its seven low bits are latched onto the command output only while the valid-address flag is set, and each command that is taken is marked by a one-cycle command strobe. Frames with bad parity or a low stop bit are dropped without any visible effect.

Top module: `ascr_top`

## Requirements
- R1: Frames are 11 bits long. Data bits arrive least significant bit first. Every bit is sampled once, `CLK_DIV/2` clock cycles into its bit period, and a bit period is `CLK_DIV` clock cycles.
- R2: A low level on the idle line that has returned high by the midpoint of the start bit is ignored. The receiver goes back to idle, raises no pulse, changes no output, and still receives the next frame correctly.
- R3: An error-free address frame (data bit 7 = 1) whose bits 6..0 equal `station_addr_i` produces exactly one `vap_o` pulse lasting one clock cycle, and leaves `addr_valid_o` high.
- R4: An error-free address frame whose bits 6..0 differ from `station_addr_i` produces no `vap_o` pulse and clears `addr_valid_o`.
- R5: An error-free command frame (data bit 7 = 0) received while `addr_valid_o` is high copies bits 6..0 to `cmd_o` and produces exactly one `cs_o` pulse lasting one clock cycle. `addr_valid_o` stays high.
- R6: A command frame received while `addr_valid_o` is low produces no `cs_o` pulse and leaves `cmd_o` unchanged.
- R7: A frame is error-free only if the XOR of its eight data bits and its parity bit is 0. A frame that fails this test changes neither `cmd_o` nor `addr_valid_o`, and it raises no pulse.
- R8: A frame whose stop bit is sampled low is discarded in the same way as a frame with a parity error.
- R9: While `rst_n` is low, `cmd_o` is 0, `addr_valid_o` is 0, and `vap_o` and `cs_o` are low.
- R10: Frames sent back to back, with the next start bit directly after the previous stop bit, are all received.
- R11: `cmd_o` changes only in a cycle in which `cs_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| station_addr_i | input | 7 | Address of this station |
| cmd_o | output | 7 | Last accepted command word |
| vap_o | output | 1 | One-cycle pulse on an address match |
| cs_o | output | 1 | One-cycle pulse when a command is accepted |
| addr_valid_o | output | 1 | Valid-address flag for the transmitter |

## Verification
Two things are decided in the same clock edge: whether a command is accepted, and what state the valid-address flag holds. A command frame is accepted only on the flag's current value, and an address frame changes that flag in the same edge in which the pulse is issued. The bench stresses this by sending random address and command frames back to back with no idle gap, mixing matching, mismatching and corrupted frames. A reference model in the bench tracks the flag frame by frame, and after each stop bit the strobe count, the pulse count, the command value and the flag are all checked against that model.

// File: rtl/ascr_pkg.sv
package ascr_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2
   } rx_state_e;
endpackage

// File: rtl/ascr_line_sync.sv
module ascr_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("ascr_line_sync: STAGES must be at least 1");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else if (i == 0) chain[i] <= d_i;
            else chain[i] <= chain[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ascr_rx_frame.sv
module ascr_rx_frame
   import ascr_pkg::*;
#(
   parameter int CLK_DIV = 64,
   parameter int DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   output logic              done_o,
   output logic              ok_o,
   output logic [DATA_W-1:0] data_o
);
   localparam int CNT_W  = $clog2(CLK_DIV);
   localparam int HALF   = CLK_DIV / 2;
   localparam int NBITS  = DATA_W + 2;
   localparam int IDX_W  = $clog2(NBITS + 1);

   rx_state_e        st;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx;
   logic [NBITS-1:0] sh;
   logic [NBITS-1:0] sh_nxt;

   assign sh_nxt = {line_i, sh[NBITS-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RX_IDLE;
         cnt    <= '0;
         idx    <= '0;
         sh     <= '0;
         done_o <= 1'b0;
         ok_o   <= 1'b0;
         data_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (st)
            RX_IDLE: begin
               if (!line_i) begin
                  st  <= RX_START;
                  cnt <= CNT_W'(HALF - 1);
               end
            end
            RX_START: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else if (line_i) begin
                  st <= RX_IDLE;
               end else begin
                  st  <= RX_BITS;
                  cnt <= CNT_W'(CLK_DIV - 1);
                  idx <= '0;
               end
            end
            RX_BITS: begin
               if (cnt != '0) begin
                  cnt <= cnt - 1'b1;
               end else begin
                  sh  <= sh_nxt;
                  cnt <= CNT_W'(CLK_DIV - 1);
                  idx <= idx + 1'b1;
                  if (idx == IDX_W'(NBITS - 1)) begin
                     st     <= RX_IDLE;
                     done_o <= 1'b1;
                     data_o <= sh_nxt[DATA_W-1:0];
                     ok_o   <= ~(^sh_nxt[DATA_W:0]) & sh_nxt[NBITS-1];
                  end
               end
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> st == RX_IDLE);
   p_start_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_START && cnt == '0 && line_i) |=> (st == RX_IDLE && !done_o));
endmodule

// File: rtl/ascr_cmd_ctrl.sv
module ascr_cmd_ctrl #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic              ok_i,
   input  logic [ADDR_W:0]   data_i,
   input  logic [ADDR_W-1:0] station_i,
   output logic [ADDR_W-1:0] cmd_o,
   output logic              vap_o,
   output logic              cs_o,
   output logic              val_o
);
   logic is_addr;
   logic hit;

   assign is_addr = data_i[ADDR_W];
   assign hit     = data_i[ADDR_W-1:0] == station_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_o <= '0;
         vap_o <= 1'b0;
         cs_o  <= 1'b0;
         val_o <= 1'b0;
      end else begin
         vap_o <= 1'b0;
         cs_o  <= 1'b0;
         if (done_i && ok_i) begin
            if (is_addr) begin
               val_o <= hit;
               vap_o <= hit;
            end else if (val_o) begin
               cmd_o <= data_i[ADDR_W-1:0];
               cs_o  <= 1'b1;
            end
         end
      end
   end

   p_vap_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vap_o |=> !vap_o);
   p_cs_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_o |=> !cs_o);
   p_cs_needs_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cs_o |-> val_o);
   p_vap_sets_val_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vap_o |-> val_o);
   p_cmd_only_on_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd_o) |-> cs_o);
   p_bad_frame_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !ok_i) |=> (!vap_o && !cs_o && $stable(val_o)));
endmodule

// File: rtl/ascr_top.sv
module ascr_top #(
   parameter int CLK_DIV     = 64,
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic [ADDR_W-1:0] station_addr_i,
   output logic [ADDR_W-1:0] cmd_o,
   output logic              vap_o,
   output logic              cs_o,
   output logic              addr_valid_o
);
   localparam int DATA_W = ADDR_W + 1;

   generate
      if (CLK_DIV < 4 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("ascr_top: CLK_DIV must be even and at least 4");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ascr_top: ADDR_W must be at least 1");
      end
   endgenerate

   logic              line_s;
   logic              fr_done;
   logic              fr_ok;
   logic [DATA_W-1:0] fr_data;

   ascr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_i),
      .q_o   (line_s)
   );

   ascr_rx_frame #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_s),
      .done_o (fr_done),
      .ok_o   (fr_ok),
      .data_o (fr_data)
   );

   ascr_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (fr_done),
      .ok_i      (fr_ok),
      .data_i    (fr_data),
      .station_i (station_addr_i),
      .cmd_o     (cmd_o),
      .vap_o     (vap_o),
      .cs_o      (cs_o),
      .val_o     (addr_valid_o)
   );

   p_no_dual_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(vap_o && cs_o));
   p_reset_clear_r9: assert property (@(posedge clk)
      !rst_n |-> (cmd_o == '0 && !addr_valid_o && !vap_o && !cs_o));
endmodule

// File: tb/tb_ascr_top.sv
module tb_ascr_top;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 64;
   localparam logic [6:0] STATION = 7'h35;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic [6:0] cmd;
   logic       vap, cs, aval;

   int n_checks = 0, n_fail = 0;
   int vap_cnt = 0, cs_cnt = 0;
   int exp_vap = 0, exp_cs = 0;
   logic       exp_val = 1'b0;
   logic [6:0] exp_cmd = 7'h00;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ascr_top #(.CLK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .station_addr_i(STATION),
      .cmd_o(cmd), .vap_o(vap), .cs_o(cs), .addr_valid_o(aval));

   always @(negedge clk) begin
      if (rst_n) begin
         if (vap) vap_cnt++;
         if (cs)  cs_cnt++;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send_frame(input logic [7:0] d, input bit bad_par,
                             input bit bad_stop, input int gap);
      logic [10:0] f;
      f = {~bad_stop, (^d) ^ bad_par, d, 1'b0};
      for (int i = 0; i < 11; i++) begin
         rx = f[i];
         repeat (DIV) @(negedge clk);
      end
      rx = 1'b1;
      repeat (gap * DIV) @(negedge clk);
   endtask

   // reference model of the frame decision, then port checks
   task automatic frame_and_check(input logic [7:0] d, input bit bad_par,
                                  input bit bad_stop, input int gap);
      string tag;
      if (bad_par)       tag = "R7";
      else if (bad_stop) tag = "R8";
      else if (d[7] && d[6:0] == STATION) tag = "R3";
      else if (d[7])     tag = "R4";
      else if (exp_val)  tag = "R5";
      else               tag = "R6";
      if (!bad_par && !bad_stop) begin
         if (d[7]) begin
            exp_val = (d[6:0] == STATION);
            if (exp_val) exp_vap++;
         end else if (exp_val) begin
            exp_cmd = d[6:0];
            exp_cs++;
         end
      end
      send_frame(d, bad_par, bad_stop, gap);
      check({tag, " vap count"}, vap_cnt, exp_vap);
      check({tag, " cs count"}, cs_cnt, exp_cs);
      check({tag, " addr_valid"}, int'(aval), int'(exp_val));
      check({tag, " cmd (R1 bit order, R11)"}, int'(cmd), int'(exp_cmd));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 cmd in reset", int'(cmd), 0);
      check("R9 addr_valid in reset", int'(aval), 0);
      check("R9 pulses in reset", int'(vap) + int'(cs), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R6 command before any address
      frame_and_check({1'b0, 7'h2A}, 0, 0, 1);
      // R3 matching address then R5 command
      frame_and_check({1'b1, STATION}, 0, 0, 1);
      frame_and_check({1'b0, 7'h41}, 0, 0, 1);
      // R7 bad parity command: ignored
      frame_and_check({1'b0, 7'h13}, 1, 0, 1);
      // R8 low stop bit command: ignored
      frame_and_check({1'b0, 7'h66}, 0, 1, 2);
      // R1 bit order: asymmetric pattern
      frame_and_check({1'b0, 7'h01}, 0, 0, 1);
      // R7 bad parity address mismatch must not clear flag
      frame_and_check({1'b1, 7'h00}, 1, 0, 1);
      // R4 mismatching address clears flag, then R6 command ignored
      frame_and_check({1'b1, STATION ^ 7'h40}, 0, 0, 1);
      frame_and_check({1'b0, 7'h7F}, 0, 0, 1);

      // R2 glitch shorter than half a bit
      rx = 1'b0;
      repeat (DIV/4) @(negedge clk);
      rx = 1'b1;
      repeat (2*DIV) @(negedge clk);
      check("R2 no vap after glitch", vap_cnt, exp_vap);
      check("R2 no cs after glitch", cs_cnt, exp_cs);
      check("R2 flag after glitch", int'(aval), int'(exp_val));
      frame_and_check({1'b1, STATION}, 0, 0, 1);   // R2 next frame still received

      // R10 back-to-back frames
      frame_and_check({1'b1, STATION}, 0, 0, 0);
      frame_and_check({1'b0, 7'h55}, 0, 0, 0);
      frame_and_check({1'b0, 7'h2B}, 0, 0, 0);

      // random mix
      for (int k = 0; k < 40; k++) begin
         logic [7:0] d;
         bit bp, bs;
         int g;
         d  = 8'($urandom);
         if (d[7] && ($urandom % 2 == 0)) d[6:0] = STATION;
         bp = ($urandom % 8) == 0;
         bs = !bp && (($urandom % 10) == 0);
         g  = $urandom % 3;
         frame_and_check(d, bp, bs, g);
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule